// File: doc/BRIEF.md
# High-Speed Burst Byte Aligner

This block is the framing stage for one receive lane while that lane carries a high-speed burst. The clock-recovery and deserialiser front end delivers the received serial bits as a single-rate stream: one bit per cycle of `clk`, qualified by `hs_bit_vld`. The block also watches the two low-power line levels of the lane. It waits for the burst request handshake on those lines. It then hunts the bit stream for the fixed 8-bit leader that opens every burst and locks byte alignment on the first match. After that it packs the payload into bytes, least significant bit first.

Each byte leaves on `byte_data` with a one-cycle `byte_vld` strobe. The first byte of a burst carries `byte_sop`. The last complete byte carries `byte_eop`. The low-power lines return to the stop level when the burst ends. At that point the block drops whatever bits have not filled a byte, which covers the line-inverted trailer the transmitter appends. The block holds each finished byte back until it knows whether another byte follows, so that the end marker can sit on the real last byte. If the leader does not show up within a set number of bits, `sync_err` rises and the block ignores the rest of that burst.

Top module: `hs_byte_aligner`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `byte_vld`, `byte_sop`, `byte_eop` and `sync_err` are all 0.
- R2: `lp_lines` is {positive line, negative line}, so LP-01 is 2'b01. Hunting starts only after three consecutive line levels: 2'b11, then 2'b01, then 2'b00. A repeat of the current level keeps the progress, and 2'b11 restarts the handshake. Serial bits received at any other time produce no byte output.
- R3: While hunting, the block matches the 8-bit leader against the last eight accepted bits. In arrival order the leader is 0,0,0,1,1,1,0,1. A match needs eight bits accepted since hunting began. A shorter history never matches, even if it happens to end in part of the leader.
- R4: A cycle with `hs_bit_vld` low adds no bit to the sync window, to the hunt count or to the byte under assembly.
- R5: The first bit after the leader goes into bit 0 of the first byte, and each later bit goes into the next higher bit. A completed byte is presented, with `byte_vld` high for one cycle, on the clock edge where the eighth bit of the next byte is taken. The last byte is presented on the edge where the lines are seen at 2'b11.
- R6: `byte_sop` is high with the first byte of a burst and with no other byte.
- R7: The burst ends when the lines read 2'b11 during payload. On that edge the last complete byte is presented with `byte_eop` high. Bits that have not completed a byte are discarded, and so is any bit offered in that same cycle. A burst that ends with no complete byte produces no output.
- R8: If `SYNC_LIMIT` accepted bits pass during hunting without a match, `sync_err` goes high on the next edge. It then stays high, with no byte output, until the lines read 2'b11.
- R9: A 2'b11 level during hunting abandons the hunt without any output. A new handshake (R2) is needed before hunting starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single-rate bit clock from the lane front end |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_lines | input | 2 | Low-power line levels {positive, negative} |
| hs_bit | input | 1 | Recovered serial bit |
| hs_bit_vld | input | 1 | Qualifies `hs_bit` in this cycle |
| byte_data | output | DATA_W | Assembled byte, LSB received first |
| byte_vld | output | 1 | One-cycle strobe for `byte_data` |
| byte_sop | output | 1 | First byte of the burst |
| byte_eop | output | 1 | Last complete byte of the burst |
| sync_err | output | 1 | Leader not found within `SYNC_LIMIT` bits |

## Verification
Some internal faults show up at the ports within one byte time. A sync window that shifts the wrong way, or that matches too early, misplaces every following byte boundary, so the first payload byte comes out with rotated bits. A byte counter that is off by one has the same kind of effect. A faulty hold-back register shows as a missing or doubled end marker at the LP-11 edge, or as a start marker on the wrong byte. A faulty hunt counter shows as `sync_err` rising one bit early or late. The bench model predicts every output on every cycle, so each of these faults fails on the first cycle where it changes an output.

// File: rtl/hs_aligner_pkg.sv
// Shared definitions for the high-speed byte aligner.
// Assumes the lane state is tracked at the single-rate bit clock.
package hs_aligner_pkg;

    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_STOP    = 3'd1,
        ST_REQ     = 3'd2,
        ST_HUNT    = 3'd3,
        ST_PAYLOAD = 3'd4,
        ST_FAIL    = 3'd5
    } lane_state_t;

    localparam logic [1:0] LP_00 = 2'b00;
    localparam logic [1:0] LP_01 = 2'b01;
    localparam logic [1:0] LP_11 = 2'b11;

endpackage

// File: rtl/hs_lp_sequencer.sv
// Lane state machine: follows the low-power request handshake, then the
// hunt/payload/fail phases of a burst. Assumes sync_hit and hunt_timeout
// are mutually exclusive single-cycle indications from the hunter.
module hs_lp_sequencer
    import hs_aligner_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  lp_lines,
    input  logic        sync_hit,
    input  logic        hunt_timeout,
    output lane_state_t state
);

    lane_state_t state_nx;

    // Next-state selection from line levels and hunter results.
    always_comb begin
        state_nx = state;
        case (state)
            ST_WAIT: if (lp_lines == LP_11) state_nx = ST_STOP;
            ST_STOP: begin
                if (lp_lines == LP_01)      state_nx = ST_REQ;
                else if (lp_lines != LP_11) state_nx = ST_WAIT;
            end
            ST_REQ: begin
                if (lp_lines == LP_00)      state_nx = ST_HUNT;
                else if (lp_lines == LP_11) state_nx = ST_STOP;
                else if (lp_lines != LP_01) state_nx = ST_WAIT;
            end
            ST_HUNT: begin
                if (lp_lines == LP_11)      state_nx = ST_STOP;
                else if (sync_hit)          state_nx = ST_PAYLOAD;
                else if (hunt_timeout)      state_nx = ST_FAIL;
            end
            ST_PAYLOAD: if (lp_lines == LP_11) state_nx = ST_STOP;
            ST_FAIL:    if (lp_lines == LP_11) state_nx = ST_STOP;
            default:    state_nx = ST_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

endmodule

// File: rtl/hs_sync_hunter.sv
// Sliding-window leader search. Bits shift in at the MSB so the oldest of
// the last DATA_W bits sits at bit 0. Assumes the window and counters are
// cleared whenever hunting is not active.
module hs_sync_hunter #(
    parameter int          DATA_W     = 8,
    parameter logic [DATA_W-1:0] SYNC_WORD = 8'hB8,
    parameter int          SYNC_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hunting,
    input  logic enable,
    input  logic bit_vld,
    input  logic bit_in,
    output logic sync_hit,
    output logic hunt_timeout
);

    localparam int FILL_W = $clog2(DATA_W);
    localparam int CNT_W  = $clog2(SYNC_LIMIT + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(SYNC_LIMIT - 1);

    logic [DATA_W-1:0] win_q;
    logic [DATA_W-1:0] win_nx;
    logic [FILL_W-1:0] fill_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              take;

    assign take   = enable && bit_vld;
    assign win_nx = {bit_in, win_q[DATA_W-1:1]};

    // Match and timeout decisions for the bit taken this cycle.
    always_comb begin
        sync_hit     = take && (fill_q == FILL_FULL) && (win_nx == SYNC_WORD);
        hunt_timeout = take && !sync_hit && (cnt_q == CNT_LAST);
    end

    // Window, fill level and hunt bit count.
    always_ff @(posedge clk) begin
        if (!rst_n || !hunting) begin
            win_q  <= '0;
            fill_q <= '0;
            cnt_q  <= '0;
        end else if (take) begin
            win_q <= win_nx;
            if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
            if (cnt_q != CNT_LAST)   cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hs_byte_packer.sv
// Packs payload bits LSB first into bytes and flags each completed byte.
// Assumes it is cleared whenever the lane is not in payload.
module hs_byte_packer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_payload,
    input  logic              enable,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val
);

    localparam int BC_W = $clog2(DATA_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

    logic [DATA_W-1:0] asm_q;
    logic [BC_W-1:0]   bcnt_q;

    assign byte_done = enable && bit_vld && (bcnt_q == BC_LAST);
    assign byte_val  = {bit_in, asm_q[DATA_W-1:1]};

    // Shift register and bit position within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_payload) begin
            asm_q  <= '0;
            bcnt_q <= '0;
        end else if (enable && bit_vld) begin
            asm_q  <= byte_val;
            bcnt_q <= byte_done ? '0 : bcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hs_byte_aligner.sv
// Top of the burst byte aligner: request tracking, leader hunt, byte
// packing and a one-byte hold-back so the end marker lands on the last
// complete byte. Assumes one recovered bit per clock at most.
module hs_byte_aligner
    import hs_aligner_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter logic [DATA_W-1:0] SYNC_WORD = 8'hB8,
    parameter int SYNC_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lp_lines,
    input  logic              hs_bit,
    input  logic              hs_bit_vld,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_vld,
    output logic              byte_sop,
    output logic              byte_eop,
    output logic              sync_err
);

    lane_state_t       state;
    logic              sync_hit;
    logic              hunt_timeout;
    logic              hunting;
    logic              in_payload;
    logic              lines_stop;
    logic              byte_done;
    logic [DATA_W-1:0] byte_val;
    logic [DATA_W-1:0] hold_q;
    logic              hold_vld_q;
    logic              hold_sop_q;
    logic              first_q;
    logic              end_burst;

    assign hunting    = (state == ST_HUNT);
    assign in_payload = (state == ST_PAYLOAD);
    assign lines_stop = (lp_lines == LP_11);
    assign end_burst  = in_payload && lines_stop;
    assign sync_err   = (state == ST_FAIL);

    hs_lp_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .lp_lines     (lp_lines),
        .sync_hit     (sync_hit),
        .hunt_timeout (hunt_timeout),
        .state        (state)
    );

    hs_sync_hunter #(
        .DATA_W     (DATA_W),
        .SYNC_WORD  (SYNC_WORD),
        .SYNC_LIMIT (SYNC_LIMIT)
    ) u_hunt (
        .clk          (clk),
        .rst_n        (rst_n),
        .hunting      (hunting),
        .enable       (hunting && !lines_stop),
        .bit_vld      (hs_bit_vld),
        .bit_in       (hs_bit),
        .sync_hit     (sync_hit),
        .hunt_timeout (hunt_timeout)
    );

    hs_byte_packer #(
        .DATA_W (DATA_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_payload (in_payload),
        .enable     (in_payload && !lines_stop),
        .bit_vld    (hs_bit_vld),
        .bit_in     (hs_bit),
        .byte_done  (byte_done),
        .byte_val   (byte_val)
    );

    // Hold-back register and registered byte output with markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
            hold_sop_q <= 1'b0;
            first_q    <= 1'b1;
            byte_data  <= '0;
            byte_vld   <= 1'b0;
            byte_sop   <= 1'b0;
            byte_eop   <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            byte_sop <= 1'b0;
            byte_eop <= 1'b0;
            if (!in_payload) begin
                first_q    <= 1'b1;
                hold_vld_q <= 1'b0;
            end else if (end_burst) begin
                hold_vld_q <= 1'b0;
                if (hold_vld_q) begin
                    byte_data <= hold_q;
                    byte_vld  <= 1'b1;
                    byte_sop  <= hold_sop_q;
                    byte_eop  <= 1'b1;
                end
            end else if (byte_done) begin
                if (hold_vld_q) begin
                    byte_data <= hold_q;
                    byte_vld  <= 1'b1;
                    byte_sop  <= hold_sop_q;
                end
                hold_q     <= byte_val;
                hold_vld_q <= 1'b1;
                hold_sop_q <= first_q;
                first_q    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hs_byte_aligner_chk.sv
// Protocol checker for the byte aligner output, bound to the top module.
// Assumes the marker rules of the brief; tracks packet framing itself.
module hs_byte_aligner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] lp_lines,
    input logic       byte_vld,
    input logic       byte_sop,
    input logic       byte_eop,
    input logic       sync_err
);

    logic in_pkt_q;

    // Tracks whether a packet has opened and not yet closed.
    always_ff @(posedge clk) begin
        if (!rst_n)                      in_pkt_q <= 1'b0;
        else if (byte_vld && byte_eop)   in_pkt_q <= 1'b0;
        else if (byte_vld && byte_sop)   in_pkt_q <= 1'b1;
    end

    AST_SOP_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sop |-> byte_vld);                                   // R6
    AST_EOP_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_eop |-> byte_vld);                                   // R7
    AST_SOP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sop |-> !in_pkt_q);                                  // R6
    AST_BODY_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_sop) |-> in_pkt_q);                    // R5
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !byte_vld);                                  // R8
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && lp_lines != 2'b11) |=> sync_err);            // R8
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && lp_lines == 2'b11) |=> !sync_err);           // R8

endmodule

bind hs_byte_aligner hs_byte_aligner_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp_lines (lp_lines),
    .byte_vld (byte_vld),
    .byte_sop (byte_sop),
    .byte_eop (byte_eop),
    .sync_err (sync_err)
);

// File: tb/hs_byte_aligner_tb.sv
module hs_byte_aligner_tb;

    localparam int LIMIT = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lp_lines = 2'b00;
    logic       hs_bit = 1'b0;
    logic       hs_bit_vld = 1'b0;
    logic [7:0] byte_data;
    logic       byte_vld, byte_sop, byte_eop, sync_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hs_byte_aligner #(.SYNC_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .lp_lines(lp_lines), .hs_bit(hs_bit),
        .hs_bit_vld(hs_bit_vld), .byte_data(byte_data), .byte_vld(byte_vld),
        .byte_sop(byte_sop), .byte_eop(byte_eop), .sync_err(sync_err));

    // Reference model state (behavioural)
    int   ms = 0;           // 0 wait,1 stop,2 req,3 hunt,4 payload,5 fail
    bit   win[$];
    int   hcnt = 0;
    bit   asmq[$];
    bit   pend = 0;
    int   pend_val = 0;
    bit   pend_first = 0;
    bit   first = 0;
    bit   e_vld, e_sop, e_eop, e_err;
    int   e_data;
    int   got[$];
    bit   lead[8] = '{0, 0, 0, 1, 1, 1, 0, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit match;
        int v;
        e_vld = 0; e_sop = 0; e_eop = 0; e_data = 0;
        if (!rst_n) begin
            ms = 0; pend = 0;
        end else begin
            case (ms)
                0: if (lp_lines == 2'b11) ms = 1;
                1: if (lp_lines == 2'b01) ms = 2; else if (lp_lines != 2'b11) ms = 0;
                2: if (lp_lines == 2'b00) begin ms = 3; win.delete(); hcnt = 0; end
                   else if (lp_lines == 2'b11) ms = 1;
                   else if (lp_lines != 2'b01) ms = 0;
                3: if (lp_lines == 2'b11) ms = 1;
                   else if (hs_bit_vld) begin
                       win.push_back(hs_bit);
                       if (win.size() > 8) void'(win.pop_front());
                       hcnt++;
                       match = (win.size() == 8);
                       for (int i = 0; i < 8; i++)
                           if (win.size() == 8 && win[i] != lead[i]) match = 0;
                       if (match) begin
                           ms = 4; asmq.delete(); pend = 0; first = 1;
                       end else if (hcnt == LIMIT) ms = 5;
                   end
                4: if (lp_lines == 2'b11) begin
                       if (pend) begin
                           e_vld = 1; e_eop = 1; e_sop = pend_first; e_data = pend_val;
                       end
                       pend = 0; ms = 1;
                   end else if (hs_bit_vld) begin
                       asmq.push_back(hs_bit);
                       if (asmq.size() == 8) begin
                           v = 0;
                           for (int i = 0; i < 8; i++) v += int'(asmq[i]) << i;
                           if (pend) begin
                               e_vld = 1; e_sop = pend_first; e_data = pend_val;
                           end
                           pend = 1; pend_val = v; pend_first = first; first = 0;
                           asmq.delete();
                       end
                   end
                5: if (lp_lines == 2'b11) ms = 1;
                default: ms = 0;
            endcase
        end
        e_err = (ms == 5);
    endtask

    task automatic compare();
        check(byte_vld == e_vld, "R5 byte_vld", byte_vld, e_vld);
        check(byte_sop == e_sop, "R6 byte_sop", byte_sop, e_sop);
        check(byte_eop == e_eop, "R7 byte_eop", byte_eop, e_eop);
        check(sync_err == e_err, "R8 sync_err", sync_err, e_err);
        if (e_vld) check(byte_data == e_data[7:0], "R5 byte_data", byte_data, e_data);
        if (byte_vld) got.push_back(int'(byte_data));
    endtask

    task automatic cyc(input logic [1:0] lp, input logic v, input logic b);
        lp_lines = lp; hs_bit_vld = v; hs_bit = b;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic request();
        cyc(2'b11, 0, 0); cyc(2'b01, 0, 0); cyc(2'b00, 0, 0);
    endtask

    task automatic send_wire(input logic [7:0] w, input logic [1:0] lp);
        for (int i = 7; i >= 0; i--) cyc(lp, 1, w[i]);
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) cyc(2'b00, 1, d[i]);
    endtask

    task automatic idle_stop(input int n);
        for (int i = 0; i < n; i++) cyc(2'b11, 0, 0);
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(2'b00, 0, 0);
        check(!byte_vld && !byte_sop && !byte_eop && !sync_err, "R1 reset outputs", 
              {byte_vld, byte_sop, byte_eop, sync_err}, 0);
        @(negedge clk); rst_n = 1;
        cyc(2'b00, 0, 0);
        check(!byte_vld && !sync_err, "R1 after reset", {byte_vld, sync_err}, 0);

        // R2: no handshake, leader and byte at LP-00 give nothing
        got.delete();
        send_wire(8'b0001_1101, 2'b00);
        send_byte(8'h5A); send_byte(8'h11);
        idle_stop(3);
        check(got.size() == 0, "R2 no output without request", got.size(), 0);

        // R2 R5 R6 R7: normal burst, three bytes plus trailer bits
        got.delete();
        request();
        for (int i = 0; i < 4; i++) cyc(2'b00, 1, 0);
        send_wire(8'b0001_1101, 2'b00);
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h81);
        cyc(2'b00, 1, 1); cyc(2'b00, 1, 1); cyc(2'b00, 1, 1);
        idle_stop(2);
        check(got.size() == 3, "R5 byte count", got.size(), 3);
        if (got.size() == 3) begin
            check(got[0] == 'hA5, "R5 byte0 LSB first", got[0], 'hA5);
            check(got[1] == 'h3C, "R5 byte1", got[1], 'h3C);
            check(got[2] == 'h81, "R7 last byte", got[2], 'h81);
        end

        // R4: gaps in hs_bit_vld during hunt and payload
        got.delete();
        request();
        for (int i = 7; i >= 0; i--) begin
            cyc(2'b00, 0, 1);
            cyc(2'b00, 1, (8'b0001_1101 >> i) & 1);
        end
        for (int i = 0; i < 8; i++) begin
            cyc(2'b00, 1, (8'hC6 >> i) & 1);
            cyc(2'b00, 0, ~((8'hC6 >> i) & 1));
        end
        idle_stop(2);
        check(got.size() == 1 && got[0] == 'hC6, "R4 gapped byte", 
              got.size() ? got[0] : -1, 'hC6);

        // R7: single byte then five leftover bits (sop and eop together)
        got.delete();
        request();
        send_wire(8'b0001_1101, 2'b00);
        send_byte(8'h7E);
        for (int i = 0; i < 5; i++) cyc(2'b00, 1, 1);
        cyc(2'b11, 1, 1);
        idle_stop(1);
        check(got.size() == 1, "R7 leftover dropped", got.size(), 1);

        // R7: burst with no complete byte
        got.delete();
        request();
        send_wire(8'b0001_1101, 2'b00);
        for (int i = 0; i < 4; i++) cyc(2'b00, 1, 1);
        idle_stop(2);
        check(got.size() == 0, "R7 empty burst", got.size(), 0);

        // R3: partial leader early in hunt must not match
        got.delete();
        request();
        cyc(2'b00, 1, 1); cyc(2'b00, 1, 1); cyc(2'b00, 1, 1);
        cyc(2'b00, 1, 0); cyc(2'b00, 1, 1);
        send_byte(8'hF0);
        idle_stop(2);
        check(got.size() == 0, "R3 no early match", got.size(), 0);
        got.delete();
        request();
        cyc(2'b00, 1, 1); cyc(2'b00, 1, 0);
        send_wire(8'b0001_1101, 2'b00);
        send_byte(8'h24); send_byte(8'hE7);
        idle_stop(2);
        check(got.size() == 2 && got[0] == 'h24, "R3 match after noise",
              got.size() ? got[0] : -1, 'h24);

        // R8: no leader within LIMIT bits
        got.delete();
        request();
        for (int i = 0; i < LIMIT + 6; i++) cyc(2'b00, 1, 1);
        check(sync_err == 1'b1, "R8 sync_err raised", sync_err, 1);
        send_wire(8'b0001_1101, 2'b00);
        send_byte(8'h99);
        check(sync_err == 1'b1 && got.size() == 0, "R8 held, no bytes", sync_err, 1);
        idle_stop(2);
        check(sync_err == 1'b0, "R8 cleared by LP-11", sync_err, 0);

        // R9: LP-11 during hunt abandons, new request needed
        got.delete();
        request();
        for (int i = 0; i < 5; i++) cyc(2'b00, 1, 0);
        idle_stop(1);
        cyc(2'b00, 0, 0);
        send_wire(8'b0001_1101, 2'b00);
        send_byte(8'h42);
        idle_stop(2);
        check(got.size() == 0, "R9 abandoned hunt", got.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule